// File: doc/BRIEF.md
# cJTAG Escape and Activation Tracker

This block observes a two-wire compact JTAG link, the TCKC clock and the TMSC data line, without driving either. It counts how many times TMSC changes level while TCKC is held high. When TCKC next rises, that count decides whether an escape occurred and of which kind. A count of six starts the online activation sequence. The block then follows that sequence bit by bit and reports which field of the 12-bit or 36-bit activation frame the current bit belongs to. When the frame is complete, the link enters OSCAN1 mode. A count of eight or more drops the link back to standard 4-wire operation.

Both wires are sampled by the system clock through two-flop synchronizers, and all edges are detected on the synchronized copies. TCKC must therefore stay in each level for several system-clock cycles. The block has no data path and no flow control. Its three outputs are plain status signals: a mode code, a one-cycle pulse when OSCAN1 is entered, and a one-cycle request, in the same cycle, that the downstream TAP controller be forced to Test-Logic-Reset. The block does not interpret the values carried in the activation fields, and it does not unpack the three-slot OSCAN1 bit groups.

Top module: `cjtag_link_tracker`

## Requirements
- R1: After reset, `link_mode` is 0 (standard 4-wire), and neither `oscan1_enter` nor `tap_reset_req` has pulsed.
- R2: Only TMSC changes that occur while TCKC is high are counted. Changes while TCKC is low have no effect. The count is cleared at every TCKC rising edge, so two high windows of three changes each never add up to an escape.
- R3: When a TCKC rising edge ends a window with exactly 6 TMSC changes, activation starts from any mode. The bit index restarts, the frame length reverts to 12, that same edge counts as bit 1, and `link_mode` becomes 1 (activation start).
- R4: When a TCKC rising edge ends a window with 8 or more changes, `link_mode` becomes 0 from any mode. Activation progress stops, so later plain edges leave the mode at 0.
- R5: A window with 7 changes, or with 1 to 5 changes, changes nothing in 4-wire or OSCAN1 mode.
- R6: In a 12-bit frame, bits 1–4 give code 1 (start), bits 5–8 give code 2 (extension), and bits 9–12 give code 3 (check packet).
- R7: If TMSC is 0 on the rising edge of bit 8, the frame length becomes 36. Bits 9–13 then give code 4 (spare), 14–16 code 5 (delay select), 17–18 code 6 (revision), 19–23 code 7 (state select), 24–25 code 8 (ready count), 26–27 code 9 (delay count), 28–32 code 10 (scan format), and 33–36 code 3 (check packet).
- R8: On the first rising edge whose bit number exceeds the frame length, `link_mode` becomes 11 (OSCAN1). `oscan1_enter` and `tap_reset_req` are then high together for exactly one system-clock cycle.
- R9: In 4-wire or OSCAN1 mode, rising edges with no escape leave `link_mode` unchanged and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both link wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| tckc_in | input | 1 | Raw TCKC level from the link |
| tmsc_in | input | 1 | Raw TMSC level from the link |
| link_mode | output | 4 | Current link mode or activation phase code |
| oscan1_enter | output | 1 | One-cycle pulse when OSCAN1 mode is entered |
| tap_reset_req | output | 1 | One-cycle request to force the TAP to Test-Logic-Reset |

## Verification
Escape classification and activation bit advance both act on the same TCKC rising edge. That edge therefore has to apply the restart first and count itself as bit 1. The bench provokes this by issuing an escape of six in the middle of an extended 36-bit frame. The window's opening edge still advances the old frame, and the closing edge restarts it. The bench judges the result by the mode reading 1 and by OSCAN1 arriving after exactly 12 more bits rather than 36. An escape of eight inside a frame checks the other collision, in which the escape must win and later edges must no longer advance anything.

// File: rtl/cjtag_trk_pkg.sv
package cjtag_trk_pkg;

  typedef enum logic [3:0] {
    MD_FOUR_WIRE = 4'd0,
    MD_ACT_START = 4'd1,
    MD_EXT_CODE  = 4'd2,
    MD_CHECK     = 4'd3,
    MD_SPARE     = 4'd4,
    MD_DELAY_SEL = 4'd5,
    MD_REVISION  = 4'd6,
    MD_STATE_SEL = 4'd7,
    MD_READY_CNT = 4'd8,
    MD_DELAY_CNT = 4'd9,
    MD_SCAN_FMT  = 4'd10,
    MD_OSCAN1    = 4'd11
  } link_mode_e;

  // escape classes by toggle count
  localparam int ESC_ACTIVATE = 6;
  localparam int ESC_LEAVE    = 8;

  // field boundaries: a phase applies once the bit number exceeds its value
  localparam int SHORT_EXT_AFTER   = 4;
  localparam int SHORT_CHECK_AFTER = 8;
  localparam int LONG_SPARE_AFTER  = 8;
  localparam int LONG_DSEL_AFTER   = 13;
  localparam int LONG_REV_AFTER    = 16;
  localparam int LONG_SSEL_AFTER   = 18;
  localparam int LONG_RDY_AFTER    = 23;
  localparam int LONG_DCNT_AFTER   = 25;
  localparam int LONG_FMT_AFTER    = 27;
  localparam int LONG_CHECK_AFTER  = 32;

endpackage

// File: rtl/cjtag_sync.sv
module cjtag_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cjtag_esc_counter.sv
module cjtag_esc_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck_s,
  input  logic             tms_s,
  output logic             tck_rise,
  output logic [CNT_W-1:0] esc_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic tck_q, tms_q;
  logic [CNT_W-1:0] cnt_q;
  logic tms_flip;

  assign tck_rise = tck_s & ~tck_q;
  // a change counts only inside the high window, never on the rising cycle
  assign tms_flip = tck_s & tck_q & (tms_s != tms_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_q <= 1'b0;
      tms_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      tck_q <= tck_s;
      tms_q <= tms_s;
      if (tck_rise)                          cnt_q <= '0;
      else if (tms_flip && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign esc_cnt = cnt_q;

  AST_CNT_CLEARED_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    tck_rise |=> (cnt_q == '0)); // R2
  AST_CNT_HOLDS_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tck_s |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/cjtag_phase_decode.sv
module cjtag_phase_decode
  import cjtag_trk_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             long_frame,
  output link_mode_e       phase
);
  localparam logic [IDX_W-1:0] B_S_EXT  = IDX_W'(SHORT_EXT_AFTER);
  localparam logic [IDX_W-1:0] B_S_CHK  = IDX_W'(SHORT_CHECK_AFTER);
  localparam logic [IDX_W-1:0] B_L_SPR  = IDX_W'(LONG_SPARE_AFTER);
  localparam logic [IDX_W-1:0] B_L_DSEL = IDX_W'(LONG_DSEL_AFTER);
  localparam logic [IDX_W-1:0] B_L_REV  = IDX_W'(LONG_REV_AFTER);
  localparam logic [IDX_W-1:0] B_L_SSEL = IDX_W'(LONG_SSEL_AFTER);
  localparam logic [IDX_W-1:0] B_L_RDY  = IDX_W'(LONG_RDY_AFTER);
  localparam logic [IDX_W-1:0] B_L_DCNT = IDX_W'(LONG_DCNT_AFTER);
  localparam logic [IDX_W-1:0] B_L_FMT  = IDX_W'(LONG_FMT_AFTER);
  localparam logic [IDX_W-1:0] B_L_CHK  = IDX_W'(LONG_CHECK_AFTER);

  always_comb begin
    if (long_frame) begin
      if      (bit_idx > B_L_CHK)  phase = MD_CHECK;
      else if (bit_idx > B_L_FMT)  phase = MD_SCAN_FMT;
      else if (bit_idx > B_L_DCNT) phase = MD_DELAY_CNT;
      else if (bit_idx > B_L_RDY)  phase = MD_READY_CNT;
      else if (bit_idx > B_L_SSEL) phase = MD_STATE_SEL;
      else if (bit_idx > B_L_REV)  phase = MD_REVISION;
      else if (bit_idx > B_L_DSEL) phase = MD_DELAY_SEL;
      else if (bit_idx > B_L_SPR)  phase = MD_SPARE;
      else if (bit_idx > B_S_EXT)  phase = MD_EXT_CODE;
      else                         phase = MD_ACT_START;
    end else begin
      if      (bit_idx > B_S_CHK)  phase = MD_CHECK;
      else if (bit_idx > B_S_EXT)  phase = MD_EXT_CODE;
      else                         phase = MD_ACT_START;
    end
  end
endmodule

// File: rtl/cjtag_act_seq.sv
module cjtag_act_seq
  import cjtag_trk_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 6,
  parameter int SHORT_LEN = 12,
  parameter int LONG_LEN  = 36,
  parameter int EXT_BIT   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck_rise,
  input  logic [CNT_W-1:0] esc_cnt,
  input  logic             tms_s,
  output link_mode_e       mode,
  output logic             enter_pulse,
  output logic             tap_rst_pulse
);
  localparam logic [IDX_W-1:0] SHORT_L = IDX_W'(SHORT_LEN);
  localparam logic [IDX_W-1:0] LONG_L  = IDX_W'(LONG_LEN);
  localparam logic [IDX_W-1:0] EXT_L   = IDX_W'(EXT_BIT);
  localparam logic [CNT_W-1:0] ESC_S   = CNT_W'(ESC_ACTIVATE);
  localparam logic [CNT_W-1:0] ESC_X   = CNT_W'(ESC_LEAVE);

  link_mode_e       mode_q, mode_base, mode_n, phase;
  logic [IDX_W-1:0] idx_q, idx_base, idx_inc, idx_n, frame_len;
  logic             long_q, long_base, long_inc, long_n;
  logic             in_act, frame_done;
  logic             enter_q, rst_q;

  cjtag_phase_decode #(.IDX_W(IDX_W)) u_decode (
    .bit_idx   (idx_inc),
    .long_frame(long_inc),
    .phase     (phase)
  );

  always_comb begin
    mode_base = mode_q;
    idx_base  = idx_q;
    long_base = long_q;
    // escape classification comes first on the edge
    if (esc_cnt >= ESC_X) begin
      mode_base = MD_FOUR_WIRE;
    end else if (esc_cnt == ESC_S) begin
      mode_base = MD_ACT_START;
      idx_base  = '0;
      long_base = 1'b0;
    end
    in_act    = (mode_base != MD_FOUR_WIRE) && (mode_base != MD_OSCAN1);
    idx_inc   = idx_base + 1'b1;
    long_inc  = long_base | ((idx_inc == EXT_L) & ~tms_s);
    frame_len = long_inc ? LONG_L : SHORT_L;

    mode_n     = mode_base;
    idx_n      = idx_base;
    long_n     = long_base;
    frame_done = 1'b0;
    if (in_act) begin
      idx_n  = idx_inc;
      long_n = long_inc;
      if (idx_inc > frame_len) begin
        mode_n     = MD_OSCAN1;
        frame_done = 1'b1;
      end else begin
        mode_n = phase;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_FOUR_WIRE;
      idx_q   <= '0;
      long_q  <= 1'b0;
      enter_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      enter_q <= tck_rise & frame_done;
      rst_q   <= tck_rise & frame_done;
      if (tck_rise) begin
        mode_q <= mode_n;
        idx_q  <= idx_n;
        long_q <= long_n;
      end
    end
  end

  assign mode          = mode_q;
  assign enter_pulse   = enter_q;
  assign tap_rst_pulse = rst_q;

  AST_ENTER_IN_OSCAN1: assert property (@(posedge clk) disable iff (!rst_n)
    enter_q |-> (mode_q == MD_OSCAN1)); // R8
  AST_ENTER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_q |=> !enter_q); // R8
  AST_IDX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LONG_L + 1'b1); // R7
endmodule

// File: rtl/cjtag_link_tracker.sv
module cjtag_link_tracker
  import cjtag_trk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int SHORT_LEN   = 12,
  parameter int LONG_LEN    = 36,
  parameter int EXT_BIT     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tckc_in,
  input  logic       tmsc_in,
  output logic [3:0] link_mode,
  output logic       oscan1_enter,
  output logic       tap_reset_req
);
  localparam int IDX_W = $clog2(LONG_LEN + 2);

  logic [1:0]       synced;
  logic             tck_rise;
  logic [CNT_W-1:0] esc_cnt;
  link_mode_e       mode;

  cjtag_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({tckc_in, tmsc_in}),
    .q    (synced)
  );

  cjtag_esc_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tck_s   (synced[1]),
    .tms_s   (synced[0]),
    .tck_rise(tck_rise),
    .esc_cnt (esc_cnt)
  );

  cjtag_act_seq #(
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W),
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN (LONG_LEN),
    .EXT_BIT  (EXT_BIT)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tck_rise     (tck_rise),
    .esc_cnt      (esc_cnt),
    .tms_s        (synced[0]),
    .mode         (mode),
    .enter_pulse  (oscan1_enter),
    .tap_rst_pulse(tap_reset_req)
  );

  assign link_mode = mode;

  AST_ESC_STARTS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_rise && esc_cnt == CNT_W'(ESC_ACTIVATE)) |=> (link_mode == 4'd1)); // R3
  AST_ESC_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_rise && esc_cnt >= CNT_W'(ESC_LEAVE)) |=> (link_mode == 4'd0)); // R4
  AST_SEVEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_rise && esc_cnt == CNT_W'(7) && (mode == MD_FOUR_WIRE || mode == MD_OSCAN1))
      |=> $stable(link_mode)); // R5
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tck_rise |=> $stable(link_mode)); // R9
endmodule

// File: tb/tb_cjtag_link_tracker.sv
`timescale 1ns/1ps
module tb_cjtag_link_tracker;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tckc = 1'b0;
  logic tmsc = 1'b1;
  logic [3:0] link_mode;
  logic oscan1_enter, tap_reset_req;

  int total = 0, bad = 0;
  int n_enter = 0, n_rst = 0, n_split = 0;

  always #2.5 clk = ~clk;

  cjtag_link_tracker dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tckc_in      (tckc),
    .tmsc_in      (tmsc),
    .link_mode    (link_mode),
    .oscan1_enter (oscan1_enter),
    .tap_reset_req(tap_reset_req)
  );

  always @(negedge clk) if (rst_n) begin
    if (oscan1_enter) n_enter++;
    if (tap_reset_req) n_rst++;
    if (oscan1_enter != tap_reset_req) n_split++;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit tms);
    tmsc = tms; idle(HALF);
    tckc = 1'b1; idle(HALF);
    tckc = 1'b0; idle(HALF);
  endtask

  task automatic pulses(int n, bit tms);
    repeat (n) pulse(tms);
  endtask

  // opening edge, n toggles while high, then a closing edge that evaluates
  task automatic escape(int n);
    idle(HALF);
    tckc = 1'b1; idle(HALF);
    repeat (n) begin tmsc = ~tmsc; idle(3); end
    tckc = 1'b0; idle(HALF);
    tckc = 1'b1; idle(HALF);
    tckc = 1'b0; idle(HALF);
  endtask

  function automatic int long_code(int b);
    if (b > 32) return 3;
    if (b > 27) return 10;
    if (b > 25) return 9;
    if (b > 23) return 8;
    if (b > 18) return 7;
    if (b > 16) return 6;
    if (b > 13) return 5;
    if (b > 8)  return 4;
    return 2;
  endfunction

  task automatic t_reset();
    check("R1 mode", link_mode, 0);
    check("R1 pulses", n_enter + n_rst, 0);
  endtask

  task automatic t_window();
    repeat (6) begin tmsc = ~tmsc; idle(3); end
    pulse(1'b1);
    check("R2 low toggles", link_mode, 0);
    escape(3);
    escape(3);
    check("R2 split windows", link_mode, 0);
  endtask

  task automatic t_short();
    int e0 = n_enter;
    escape(6);
    check("R3 start", link_mode, 1);
    pulses(3, 1'b1);
    check("R6 bit4", link_mode, 1);
    pulse(1'b1);
    check("R6 bit5", link_mode, 2);
    pulses(3, 1'b1);
    check("R6 bit8", link_mode, 2);
    pulse(1'b1);
    check("R6 bit9", link_mode, 3);
    pulses(3, 1'b1);
    check("R6 bit12", link_mode, 3);
    check("R8 no early enter", n_enter, e0);
    pulse(1'b1);
    check("R8 oscan1", link_mode, 11);
    check("R8 enter pulse", n_enter, e0 + 1);
    check("R8 reset pulse", n_rst, e0 + 1);
    check("R8 same cycle", n_split, 0);
  endtask

  task automatic t_ignore();
    int e0 = n_enter;
    escape(7);
    check("R5 seven in oscan1", link_mode, 11);
    escape(5);
    check("R5 five in oscan1", link_mode, 11);
    pulses(10, 1'b0);
    check("R9 plain edges oscan1", link_mode, 11);
    check("R9 no pulse", n_enter, e0);
  endtask

  task automatic t_exit();
    escape(8);
    check("R4 leave oscan1", link_mode, 0);
    escape(12);
    check("R4 leave from 4-wire", link_mode, 0);
    escape(7);
    check("R5 seven in 4-wire", link_mode, 0);
    pulses(5, 1'b1);
    check("R9 plain edges 4-wire", link_mode, 0);
  endtask

  task automatic t_long();
    int e0 = n_enter;
    escape(6);
    pulses(6, 1'b1);
    pulse(1'b0);
    check("R7 bit8", link_mode, 2);
    for (int b = 9; b <= 36; b++) begin
      pulse(1'b1);
      check($sformatf("R7 bit%0d", b), link_mode, long_code(b));
    end
    check("R7 no enter at 36", n_enter, e0);
    pulse(1'b1);
    check("R8 long oscan1", link_mode, 11);
    check("R8 long enter", n_enter, e0 + 1);
  endtask

  task automatic t_abort();
    int e0 = n_enter;
    escape(6);
    pulses(3, 1'b1);
    escape(8);
    check("R4 abort activation", link_mode, 0);
    pulses(20, 1'b0);
    check("R4 frozen after abort", link_mode, 0);
    check("R4 no enter", n_enter, e0);
  endtask

  task automatic t_restart();
    int e0 = n_enter;
    escape(6);
    pulses(6, 1'b1);
    pulse(1'b0);
    pulse(1'b1);
    check("R7 spare before restart", link_mode, 4);
    escape(6);
    check("R3 restart", link_mode, 1);
    pulses(11, 1'b1);
    check("R6 restart bit12", link_mode, 3);
    pulse(1'b1);
    check("R3 short frame after restart", link_mode, 11);
    check("R8 restart enter", n_enter, e0 + 1);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(HALF);
    t_reset();
    t_window();
    t_short();
    t_ignore();
    t_exit();
    t_long();
    t_abort();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #750000;
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule